// File: doc/BRIEF.md
# Six-Tap Half-Sample Luma Interpolator

This block produces one luma half-sample value from a row of reference pixels. A caller gives it an integer pixel position, a flag that picks the reference row, and the largest valid column and row indices of the picture. The block then reads six neighbouring 8-bit pixels, one per cycle, through a synchronous read port. The port returns data one cycle after each request.

Each tap's column is clamped to the picture, so positions near an edge repeat the border pixel and no padded frame is needed. The row is clamped the same way. The six pixels are weighted by fixed coefficients and summed in a signed accumulator. The sum is rounded, scaled down by 32 and saturated to 0..255. The result appears on the output together with a one-cycle completion pulse.

Top module: `halfpel_fir6`

## Requirements
- R1: After a start is accepted, `rdEn` is high for exactly six consecutive cycles. Read k (k = 0..5) requests column `posX + k - 2`, so the taps are issued in order of increasing offset from -2 to +3.
- R2: Every requested column is clamped into 0..`maxCol`. A column below 0 reads column 0, and a column above `maxCol` reads column `maxCol`.
- R3: The requested row is `posY` when `vertSel` is 1 and `posY + 1` when `vertSel` is 0.
- R4: The requested row is clamped to at most `maxRow`.
- R5: The tap weights, in order of increasing offset, are 1, -5, 20, 20, -5, 1. The result is (weighted sum + 16) shifted arithmetically right by 5, which rounds toward minus infinity for negative sums.
- R6: The scaled result is saturated: a negative value gives 0 and a value above 255 gives 255.
- R7: The pixel used for read k is the `rdData` value present in the cycle after that read was requested.
- R8: `done` is a single-cycle pulse that rises on the seventh rising clock edge after the edge that accepted `start`. `pixOut` changes only together with `done` and holds its value between operations.
- R9: A `start` that arrives while `busy` is high is ignored: the running operation keeps its inputs and its timing.
- R10: While reset is asserted, `busy`, `done` and `rdEn` are 0 and `pixOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one interpolation; accepted only while idle |
| posX | input | COORD_W | Integer column of the interpolation point |
| posY | input | COORD_W | Integer row of the interpolation point |
| vertSel | input | 1 | Row select: 1 uses posY, 0 uses posY+1 |
| maxCol | input | COORD_W | Largest valid column index |
| maxRow | input | COORD_W | Largest valid row index |
| rdEn | output | 1 | Pixel read request |
| rdX | output | COORD_W | Requested column, already clamped |
| rdY | output | COORD_W | Requested row, already clamped |
| rdData | input | 8 | Pixel returned one cycle after rdEn |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse marking a new pixOut |
| pixOut | output | 8 | Interpolated, saturated pixel |

## Verification
The embedded properties check the following on every cycle:
- each issued column stays within the captured column bound;
- the captured row never exceeds the row bound;
- the row follows the select flag when no clamping applies;
- the read burst runs unbroken to its sixth read;
- `done` never lasts longer than one cycle;
- `pixOut` changes only together with `done`.

The arithmetic itself can only be shown by the bench scenarios. These cover the coefficient order, the rounding of negative sums, saturation at both ends, and edge repetition at all four borders, including a picture narrower than the filter. They also cover whether a `start` during a busy operation is really ignored. A behavioural model compares these against the design on every clock.

// File: rtl/halfpel_pkg.sv
package halfpel_pkg;

  localparam int TAPS = 6;
  localparam int TAP_W = $clog2(TAPS);
  localparam int LEFT_REACH = 2;
  localparam int SCALE_SHIFT = 5;
  localparam int ROUND_ADD = 1 << (SCALE_SHIFT - 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT
  } state_t;

  typedef struct packed {
    logic             load;
    logic             issue;
    logic [TAP_W-1:0] issueTap;
    logic             accum;
    logic [TAP_W-1:0] accTap;
    logic             finish;
  } strobe_t;

  function automatic logic signed [7:0] tapCoef(input logic [TAP_W-1:0] idx);
    case (idx)
      3'd0, 3'd5: tapCoef = 8'sd1;
      3'd1, 3'd4: tapCoef = -8'sd5;
      3'd2, 3'd3: tapCoef = 8'sd20;
      default:    tapCoef = 8'sd0;
    endcase
  endfunction

endpackage

// File: rtl/halfpel_ctrl.sv
module halfpel_ctrl
  import halfpel_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t strb,
  output logic    busy
);

  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(TAPS - 1);

  state_t           state;
  logic [TAP_W-1:0] tapCnt;
  logic             accPend;
  logic [TAP_W-1:0] accTapQ;
  logic             finishQ;

  always_comb begin
    strb.load     = (state == ST_IDLE) && start;
    strb.issue    = (state == ST_FETCH);
    strb.issueTap = tapCnt;
    strb.accum    = accPend;
    strb.accTap   = accTapQ;
    strb.finish   = finishQ;
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tapCnt  <= '0;
      accPend <= 1'b0;
      accTapQ <= '0;
      finishQ <= 1'b0;
    end else begin
      accPend <= strb.issue;
      accTapQ <= tapCnt;
      finishQ <= strb.issue && (tapCnt == LAST_TAP);
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_FETCH;
            tapCnt <= '0;
          end
        end
        ST_FETCH: begin
          if (tapCnt == LAST_TAP) state <= ST_WAIT;
          else                    tapCnt <= tapCnt + 1'b1;
        end
        ST_WAIT: begin
          if (finishQ) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BURST_UNBROKEN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && tapCnt != LAST_TAP) |=> strb.issue); // R1

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && start && tapCnt != LAST_TAP) |=> (tapCnt == $past(tapCnt) + 1'b1)); // R9

endmodule

// File: rtl/halfpel_dp.sv
module halfpel_dp
  import halfpel_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int PIX_W   = 8,
  parameter int ACC_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [COORD_W-1:0] posX,
  input  logic [COORD_W-1:0] posY,
  input  logic               vertSel,
  input  logic [COORD_W-1:0] maxCol,
  input  logic [COORD_W-1:0] maxRow,
  input  logic [PIX_W-1:0]   rdData,
  output logic [COORD_W-1:0] rdX,
  output logic [COORD_W-1:0] rdY,
  output logic [PIX_W-1:0]   pixOut,
  output logic               done
);

  localparam int SW = COORD_W + 2;
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  logic [COORD_W-1:0] baseX;
  logic [COORD_W-1:0] colMax;
  logic [COORD_W-1:0] rowQ;
  logic signed [ACC_W-1:0] acc;

  // row selection and clamp, resolved once at load
  logic [COORD_W:0]   rowWant;
  logic [COORD_W-1:0] rowClamped;
  always_comb begin
    rowWant    = vertSel ? {1'b0, posY} : ({1'b0, posY} + 1'b1);
    rowClamped = (rowWant > {1'b0, maxRow}) ? maxRow : rowWant[COORD_W-1:0];
  end

  // per-tap column with edge clamp
  logic signed [SW-1:0] tapPos;
  always_comb begin
    tapPos = $signed({2'b00, baseX}) + $signed(SW'(strb.issueTap))
             - $signed(SW'(LEFT_REACH));
    if (tapPos < 0)
      rdX = '0;
    else if (tapPos > $signed({2'b00, colMax}))
      rdX = colMax;
    else
      rdX = tapPos[COORD_W-1:0];
  end

  assign rdY = rowQ;

  // multiply-accumulate and final scale/clip
  logic signed [ACC_W-1:0] pixS, coefS, prod, sumAll, scaled;
  logic [PIX_W-1:0]        clipped;
  always_comb begin
    pixS   = $signed({{(ACC_W-PIX_W){1'b0}}, rdData});
    coefS  = ACC_W'(tapCoef(strb.accTap));
    prod   = pixS * coefS;
    sumAll = acc + prod;
    scaled = (sumAll + $signed(ACC_W'(ROUND_ADD))) >>> SCALE_SHIFT;
    if (scaled < 0)
      clipped = '0;
    else if (scaled > $signed(ACC_W'(PIX_MAX)))
      clipped = PIX_W'(PIX_MAX);
    else
      clipped = scaled[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseX  <= '0;
      colMax <= '0;
      rowQ   <= '0;
      acc    <= '0;
      pixOut <= '0;
      done   <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.load) begin
        baseX  <= posX;
        colMax <= maxCol;
        rowQ   <= rowClamped;
        acc    <= '0;
      end else if (strb.accum) begin
        acc <= sumAll;
      end
      if (strb.finish) pixOut <= clipped;
    end
  end

  AST_COL_IN_PICTURE: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> (rdX <= colMax)); // R2

  AST_ROW_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (rdY <= $past(maxRow))); // R4

  AST_ROW_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && vertSel && posY <= maxRow) |=> (rdY == $past(posY))); // R3

  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(pixOut)); // R8

endmodule

// File: rtl/halfpel_fir6.sv
module halfpel_fir6
  import halfpel_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int ACC_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COORD_W-1:0] posX,
  input  logic [COORD_W-1:0] posY,
  input  logic               vertSel,
  input  logic [COORD_W-1:0] maxCol,
  input  logic [COORD_W-1:0] maxRow,
  output logic               rdEn,
  output logic [COORD_W-1:0] rdX,
  output logic [COORD_W-1:0] rdY,
  input  logic [7:0]         rdData,
  output logic               busy,
  output logic               done,
  output logic [7:0]         pixOut
);

  strobe_t strb;

  halfpel_ctrl ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .busy  (busy)
  );

  halfpel_dp #(
    .COORD_W (COORD_W),
    .PIX_W   (8),
    .ACC_W   (ACC_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .posX    (posX),
    .posY    (posY),
    .vertSel (vertSel),
    .maxCol  (maxCol),
    .maxRow  (maxRow),
    .rdData  (rdData),
    .rdX     (rdX),
    .rdY     (rdY),
    .pixOut  (pixOut),
    .done    (done)
  );

  assign rdEn = strb.issue;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

endmodule

// File: tb/halfpel_fir6_tb_top.sv
module halfpel_fir6_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] posX = '0, posY = '0, maxCol = '0, maxRow = '0;
  logic          vertSel = 1'b0;
  logic          rdEn, busy, done;
  logic [CW-1:0] rdX, rdY;
  logic [7:0]    rdData = '0;
  logic [7:0]    pixOut;

  int total = 0;
  int bad = 0;
  int patMode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halfpel_fir6 #(.COORD_W(CW), .ACC_W(16)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .posX(posX), .posY(posY),
    .vertSel(vertSel), .maxCol(maxCol), .maxRow(maxRow), .rdEn(rdEn),
    .rdX(rdX), .rdY(rdY), .rdData(rdData), .busy(busy), .done(done),
    .pixOut(pixOut)
  );

  function automatic int pixAt(int x, int y);
    if (patMode == 1) return ((x % 6) == 2 || (x % 6) == 3) ? 0 : 255;
    if (patMode == 2) return ((x % 6) == 2 || (x % 6) == 3) ? 255 : 0;
    return (x * 37 + y * 91 + x * y * 5 + 11) % 256;
  endfunction

  function automatic int clampI(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // read port model: request seen mid-cycle, data returned at next edge (R7)
  logic          pend = 1'b0;
  logic [CW-1:0] pendX = '0, pendY = '0;
  always @(negedge clk) begin
    pend  <= rdEn;
    pendX <= rdX;
    pendY <= rdY;
  end
  always @(posedge clk) if (pend) rdData <= 8'(pixAt(int'(pendX), int'(pendY)));

  // behavioural reference model
  int mActive = 0, mP = 0, mDone = 0, mPix = 0;
  int mX = 0, mRow = 0, mMaxC = 0;
  int coefs[6] = '{1, -5, 20, 20, -5, 1};

  function automatic int modelPix(int x, int row, int mc);
    int sum = 0;
    int r;
    for (int k = 0; k < 6; k++) sum += coefs[k] * pixAt(clampI(x + k - 2, 0, mc), row);
    r = (sum + 16) >>> 5;
    return clampI(r, 0, 255);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mActive <= 0; mP <= 0; mDone <= 0; mPix <= 0;
    end else begin
      mDone <= 0;
      if (mActive != 0) begin
        if (mP == 6) begin
          mActive <= 0;
          mDone   <= 1;
          mPix    <= modelPix(mX, mRow, mMaxC);
        end else mP <= mP + 1;
      end else if (start) begin
        mActive <= 1;
        mP      <= 0;
        mX      <= int'(posX);
        mMaxC   <= int'(maxCol);
        mRow    <= clampI(vertSel ? int'(posY) : int'(posY) + 1, 0, int'(maxRow));
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      int expRd;
      expRd = (mActive != 0 && mP <= 5) ? 1 : 0;
      check("R1 rdEn", int'(rdEn), expRd);
      if (expRd != 0) begin
        check("R1/R2 rdX", int'(rdX), clampI(mX + mP - 2, 0, mMaxC));
        check("R3/R4 rdY", int'(rdY), mRow);
      end
      check("R9 busy", int'(busy), mActive);
      check("R8 done", int'(done), mDone);
      check("R5/R6/R7 pixOut", int'(pixOut), mPix);
    end
  end

  task automatic runOp(int x, int y, int v, int mc, int mr);
    @(posedge clk); #1;
    posX = CW'(x); posY = CW'(y); vertSel = v[0];
    maxCol = CW'(mc); maxRow = CW'(mr);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (8) @(posedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10 busy", int'(busy), 0);
    check("R10 done", int'(done), 0);
    check("R10 rdEn", int'(rdEn), 0);
    check("R10 pixOut", int'(pixOut), 0);
    @(posedge clk); #1;
    rstN = 1'b1;

    runOp(20, 10, 1, 63, 31);   // interior, row = posY
    runOp(20, 10, 0, 63, 31);   // interior, row = posY+1
    runOp(0, 5, 1, 63, 31);     // left edge R2
    runOp(1, 5, 0, 63, 31);
    runOp(63, 7, 1, 63, 31);    // right edge R2
    runOp(62, 7, 0, 63, 31);
    runOp(30, 0, 1, 63, 31);    // top edge R3
    runOp(30, 31, 0, 63, 31);   // bottom edge clamp R4
    runOp(12, 40, 1, 63, 31);   // row beyond picture R4
    runOp(0, 31, 0, 63, 31);    // corner
    runOp(2, 3, 1, 3, 7);       // narrow picture, both sides clamp
    runOp(0, 0, 0, 0, 0);       // single-pixel picture

    patMode = 1;
    runOp(8, 4, 1, 63, 31);     // negative sum -> 0 (R6, R5 floor)
    runOp(9, 4, 1, 63, 31);
    patMode = 2;
    runOp(8, 4, 1, 63, 31);     // overflow -> 255 (R6)
    runOp(11, 4, 1, 63, 31);
    patMode = 0;

    // R9: start held while busy, with different inputs
    @(posedge clk); #1;
    posX = 40; posY = 9; vertSel = 1'b1; maxCol = 63; maxRow = 31;
    start = 1'b1;
    @(posedge clk); #1;
    posX = 2; posY = 30; vertSel = 1'b0;
    repeat (4) @(posedge clk);
    #1 start = 1'b0;
    repeat (10) @(posedge clk);

    // back-to-back: start held until the block becomes idle again
    @(posedge clk); #1;
    posX = 50; posY = 20; vertSel = 1'b0; start = 1'b1;
    repeat (8) @(posedge clk);
    #1 posX = 5; posY = 6;
    @(posedge clk); #1 start = 1'b0;
    repeat (12) @(posedge clk);

    summary();
    $finish;
  end

endmodule